// File: doc/BRIEF.md
# Serial CRC-8 Identity Code Checker

This block checks a 64-bit device identity code that arrives one bit at a time. The code holds an 8-bit family byte, a 48-bit serial number and an 8-bit check byte, in that order. Each field is sent least significant bit first. A one-bit-per-step CRC register implements the reflected form of x^8 + x^5 + x^4 + 1. It starts from zero and takes every accepted bit, including the check byte. When the code is intact, the register is back at zero after the last bit.

The block also collects the first eight received bits and compares them with a family code set by a parameter. A host that receives the identity code feeds the bits in with a valid strobe and pulses a clear before each new code. It reads the done, good and family-match flags after the last bit. Any stream of data bytes followed by their check byte can be checked the same way, as long as it fits the configured bit count.

Top module: `idcode_crc_checker`

## Requirements
- R1: After reset or one cycle after a clear strobe, crc_o is 00h, count_o is 0, and done_o, crc_good_o and family_match_o are all 0.
- R2: Each accepted bit updates the register one cycle later as follows. Let fb = bit XOR crc[0]. The new crc is (crc >> 1) XOR (fb ? 8Ch : 00h).
- R3: count_o goes up by one for each accepted bit. In a cycle without bit_valid_i, the CRC register and the count do not change.
- R4: After 56 bits, crc_o equals the CRC of those 56 bits. Bits are numbered 0 to 55 in arrival order, with the family code in bits 0 to 7.
- R5: done_o is 1 exactly when 64 bits have been accepted. Later valid bits are ignored, so crc_o and count_o stay the same until the next clear.
- R6: crc_good_o is 1 only when done_o is 1 and crc_o is 00h. A code whose check byte is correct gives 1. Flipping any one of its 64 bits gives 0.
- R7: The first received bit is the least significant bit of the captured family byte. family_match_o is 1 only when at least 8 bits have been taken and that byte equals EXPECT_FAMILY (default 1Bh). It is 0 while fewer than 8 bits have arrived.
- R8: If clear_i and bit_valid_i are both high in the same cycle, the clear wins and the bit is discarded. The next state is the cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Restarts the check for a new code |
| bit_valid_i | input | 1 | bit_i carries a code bit this cycle |
| bit_i | input | 1 | Serial code bit, LSB of each field first |
| crc_o | output | 8 | Current CRC register |
| count_o | output | CNT_W (7) | Number of bits accepted |
| done_o | output | 1 | All code bits received |
| crc_good_o | output | 1 | Code received with zero remainder |
| family_match_o | output | 1 | First byte equals the expected family code |

## Verification
A clear and a valid bit can arrive in the same cycle. The bench raises both strobes together twice: once in the middle of a stream and once after done has risen. It then checks that the count and register read zero, so the bit was dropped. It then sends one bit with value 1 and checks that the register becomes 8Ch and the count becomes one. This shows the engine restarts cleanly. The same kind of collision, a bit arriving after done, is judged by checking that the remainder and count do not move.

// File: rtl/idcc_pkg.sv
package idcc_pkg;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;
    localparam logic [7:0] DEFAULT_FAMILY = 8'h1B;
    typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/idcc_crc_step.sv
module idcc_crc_step #(
    parameter int W = 8,
    parameter logic [W-1:0] POLY = 8'h8C
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    always_comb begin
        fb    = bit_i ^ crc_i[0];
        crc_o = (crc_i >> 1) ^ ({W{fb}} & POLY);
    end
endmodule

// File: rtl/idcc_field_tracker.sv
module idcc_field_tracker #(
    parameter int CODE_BITS = 64,
    parameter int FAM_BITS  = 8,
    parameter int CNT_W     = $clog2(CODE_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             take_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             in_family_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_BITS);
    localparam logic [CNT_W-1:0] FAMN = CNT_W'(FAM_BITS);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear_i)
            count_d = '0;
        else if (take_i)
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o     = count_q;
    assign done_o      = (count_q == LAST);
    assign in_family_o = (count_q < FAMN);
endmodule

// File: rtl/idcode_crc_checker.sv
module idcode_crc_checker
    import idcc_pkg::*;
#(
    parameter int          CODE_BITS     = 64,
    parameter int          FAM_BITS      = 8,
    parameter logic [7:0]  EXPECT_FAMILY = DEFAULT_FAMILY,
    parameter int          CNT_W         = $clog2(CODE_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             crc_good_o,
    output logic             family_match_o
);
    typedef struct packed {
        crc_t                crc;
        logic [FAM_BITS-1:0] fam;
    } state_t;

    state_t st_d, st_q;
    crc_t   crc_next;
    logic   take;
    logic   done;
    logic   in_family;

    idcc_field_tracker #(
        .CODE_BITS(CODE_BITS),
        .FAM_BITS (FAM_BITS),
        .CNT_W    (CNT_W)
    ) tracker_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .take_i     (take),
        .count_o    (count_o),
        .done_o     (done),
        .in_family_o(in_family)
    );

    idcc_crc_step #(
        .W   (CRC_W),
        .POLY(POLY_REFL)
    ) step_i (
        .crc_i(st_q.crc),
        .bit_i(bit_i),
        .crc_o(crc_next)
    );

    assign take = bit_valid_i && !clear_i && !done;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (take) begin
            st_d.crc = crc_next;
            if (in_family)
                st_d.fam = {bit_i, st_q.fam[FAM_BITS-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_o          = st_q.crc;
    assign done_o         = done;
    assign crc_good_o     = done && (st_q.crc == '0);
    assign family_match_o = !in_family && (st_q.fam == EXPECT_FAMILY[FAM_BITS-1:0]);
endmodule

// File: rtl/idcc_checker.sv
module idcc_checker #(
    parameter int CODE_BITS = 64,
    parameter int FAM_BITS  = 8,
    parameter int CNT_W     = $clog2(CODE_BITS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             bit_valid_i,
    input logic             bit_i,
    input logic [7:0]       crc_o,
    input logic [CNT_W-1:0] count_o,
    input logic             done_o,
    input logic             crc_good_o,
    input logic             family_match_o
);
    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0 && crc_o == '0 && !done_o && !crc_good_o && !family_match_o)); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && !clear_i && !done_o) |=> count_o == CNT_W'($past(count_o) + 1'b1)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid_i && !clear_i) |=> ($stable(crc_o) && $stable(count_o))); // R3
    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> ($stable(crc_o) && $stable(count_o) && done_o)); // R5
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> count_o == CNT_W'(CODE_BITS)); // R5
    AST_GOOD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        crc_good_o |-> (done_o && crc_o == '0)); // R6
    AST_FAMILY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o < CNT_W'(FAM_BITS)) |-> !family_match_o); // R7
endmodule

bind idcode_crc_checker idcc_checker #(
    .CODE_BITS(CODE_BITS),
    .FAM_BITS (FAM_BITS),
    .CNT_W    (CNT_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear_i),
    .bit_valid_i   (bit_valid_i),
    .bit_i         (bit_i),
    .crc_o         (crc_o),
    .count_o       (count_o),
    .done_o        (done_o),
    .crc_good_o    (crc_good_o),
    .family_match_o(family_match_o)
);

// File: tb/idcode_crc_checker_tb_top.sv
`timescale 1ns/1ps
module idcode_crc_checker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       bit_valid_i = 1'b0;
    logic       bit_i = 1'b0;
    logic [7:0] crc_o;
    logic [6:0] count_o;
    logic       done_o, crc_good_o, family_match_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    idcode_crc_checker dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .bit_valid_i(bit_valid_i),
        .bit_i(bit_i), .crc_o(crc_o), .count_o(count_o), .done_o(done_o),
        .crc_good_o(crc_good_o), .family_match_o(family_match_o)
    );

    // Remainder of the reflected x^8+x^5+x^4+1 division, bit n of the stream first.
    function automatic logic [7:0] model_crc(input logic [63:0] code, input int nbits);
        int r = 0;
        for (int n = 0; n < nbits; n++) begin
            r = r ^ int'(code[n]);
            if (r % 2 == 1) r = (r / 2) ^ 140;
            else            r = r / 2;
        end
        return 8'(r);
    endfunction

    function automatic logic [63:0] make_code(input logic [7:0] fam, input logic [47:0] ser);
        logic [63:0] c;
        c = {8'h00, ser, fam};
        c[63:56] = model_crc(c, 56);
        return c;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic b);
        @(negedge clk);
        bit_valid_i = 1'b1;
        bit_i = b;
        @(negedge clk);
        bit_valid_i = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
    endtask

    task automatic collide(input logic b);
        @(negedge clk);
        clear_i = 1'b1;
        bit_valid_i = 1'b1;
        bit_i = b;
        @(negedge clk);
        clear_i = 1'b0;
        bit_valid_i = 1'b0;
    endtask

    task automatic run_code(input logic [63:0] code, input int good, input int match, input string tag);
        clr();
        for (int n = 0; n < 64; n++) begin
            push(code[n]);
            if (n == 6)  check({tag, " R7 early match"}, family_match_o, 0);
            if (n == 55) check({tag, " R4 crc after 56"}, crc_o, model_crc(code, 56));
        end
        check({tag, " R5 done"}, done_o, 1);
        check({tag, " R6 good"}, crc_good_o, good);
        check({tag, " R7 match"}, family_match_o, match);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] code;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset crc", crc_o, 0);
        check("R1 reset count", count_o, 0);
        check("R1 reset flags", {done_o, crc_good_o, family_match_o}, 0);

        // R2 per-bit register trace
        code = make_code(8'h1B, 48'hA5C3_0F12_9E77);
        clr();
        for (int n = 0; n < 64; n++) begin
            push(code[n]);
            check("R2 per-bit crc", crc_o, model_crc(code, n + 1));
            check("R3 count", count_o, n + 1);
        end

        // R3 idle cycles hold state
        clr();
        for (int n = 0; n < 20; n++) push(code[n]);
        repeat (5) @(negedge clk);
        check("R3 idle count", count_o, 20);
        check("R3 idle crc", crc_o, model_crc(code, 20));

        // R1 clear mid stream
        clr();
        check("R1 clear count", count_o, 0);
        check("R1 clear crc", crc_o, 0);

        // R4 R6 R7 family sweep
        for (int f = 0; f < 256; f++) begin
            code = make_code(8'(f), {8'(f * 7), 40'h13_5792_4680 ^ 40'(f * 40'h1_0101)});
            run_code(code, 1, (f == 27) ? 1 : 0, "sweep");
        end

        // R6 every single-bit error
        code = make_code(8'h1B, 48'h0000_DEAD_BEEF);
        for (int k = 0; k < 64; k++) begin
            logic [63:0] bad;
            bad = code;
            bad[k] = ~bad[k];
            run_code(bad, 0, (k < 8) ? 0 : 1, "flip");
        end

        // R5 bits after done are ignored
        run_code(code, 1, 1, "base");
        for (int n = 0; n < 5; n++) push(1'b1);
        check("R5 post-done count", count_o, 64);
        check("R5 post-done crc", crc_o, 0);
        check("R5 post-done good", crc_good_o, 1);

        // R8 clear and bit together, after done
        collide(1'b1);
        check("R8 collide count after done", count_o, 0);
        check("R8 collide crc after done", crc_o, 0);

        // R8 clear and bit together, mid stream
        for (int n = 0; n < 10; n++) push(code[n]);
        collide(1'b1);
        check("R8 collide count", count_o, 0);
        check("R8 collide crc", crc_o, 0);
        check("R8 collide flags", {done_o, crc_good_o, family_match_o}, 0);
        push(1'b1);
        check("R8 restart count", count_o, 1);
        check("R2 restart crc", crc_o, 8'h8C);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule